// File: doc/BRIEF.md
# Accumulator Processor Core

This block is a compact 16-bit processor built around one accumulator. A hardwired multi-cycle state machine steers a small datapath. The datapath holds the accumulator, a program counter, an address-out register, a data-in register and a five-function ALU. Each instruction takes one fetch cycle and then one to three execute cycles. The core uses one external memory that holds both program and data. Each cycle it drives an address, a 2-bit operation code and write data, and it samples the read data.

The memory port is a plain synchronous request port with no back-pressure. Whenever the operation code says read, the memory must present the addressed word on `mem_rdata` within the same cycle. A write is committed at the clock edge that ends the cycle in which the operation code says write. Addresses count bytes and each instruction word is two bytes wide, so sequential execution steps the program counter by 2.

Top module: `acc_core`

## Requirements
- R1: While `rst` is high and in the two cycles after it falls, `mem_op` is 00 (idle). The first memory access is a read of address 0 in the third cycle after release.
- R2: An instruction word holds an indirect flag in bit 15, an opcode in bits 14:10 and an operand field X in bits 9:0. Instructions without a control transfer are fetched from consecutive even addresses. At the start of each fetch cycle the program counter equals the fetch address plus 2.
- R3: Opcode 00101 (load) reads the word at address X two cycles after its fetch and places it in the accumulator. The next fetch follows two cycles later.
- R4: Opcode 00100 (store) drives `mem_op` = 10 two cycles after its fetch, with address X and the accumulator value on `mem_wdata`. The next fetch follows in the cycle after the write.
- R5: Opcode 00010 (branch if negative) with accumulator bit 15 set fetches from X three cycles after its own fetch, and then continues at X+2. With bit 15 clear, the next sequential instruction is fetched two cycles after.
- R6: Opcode 00011 (jump) fetches from X two cycles after its own fetch.
- R7: Opcode 00000 inverts every accumulator bit. Opcode 00001 shifts the accumulator right by one, filling bit 15 with 0.
- R8: Opcode 00110 ANDs the accumulator with X zero-extended to 16 bits. Opcode 00111 adds that value modulo 2^16.
- R9: The indirect flag has no effect. It causes no extra memory access, and the operand is taken exactly as with the flag clear.
- R10: Opcode bits 14:13 are not decoded. Only bits 12:10 select the instruction.
- R11: `mem_op` encodes idle as 00, read as 01 and write as 10, and never takes the value 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | ADDR_W | Byte address of the current memory access |
| mem_op | output | 2 | Memory operation: 00 idle, 01 read, 10 write |
| mem_wdata | output | DATA_W | Write data, valid when `mem_op` is 10 |
| mem_rdata | input | DATA_W | Read data, returned in the same cycle as the read request |

## Verification
The bench builds the core with the default widths: a 16-bit word and a 10-bit operand field. With these widths the operand field covers the whole 1 KiB address space, so one small program can reach every instruction form and its data words. The program exercises a taken and a not-taken branch, a jump, and an add that wraps from all-ones to zero. It also places flagged-indirect loads and ANDs where indirect behaviour would produce a visibly different bus trace. A scoreboard checks the exact cycle spacing of every bus access, so any extra or missing execute state appears as a timing mismatch.

// File: rtl/acc_pkg.sv
package acc_pkg;

  typedef enum logic [3:0] {
    ST_RESET1 = 4'b0000,
    ST_RESET2 = 4'b0001,
    ST_FETCH  = 4'b0010,
    ST_AOPR   = 4'b0011,
    ST_SOPR   = 4'b0100,
    ST_STORE1 = 4'b0101,
    ST_STORE2 = 4'b0110,
    ST_STORE3 = 4'b0111,
    ST_LOAD1  = 4'b1000,
    ST_LOAD2  = 4'b1001,
    ST_LOAD3  = 4'b1010,
    ST_BRN1   = 4'b1011,
    ST_BRN2   = 4'b1100,
    ST_JUMP   = 4'b1101
  } state_e;

  typedef enum logic [2:0] {
    ALU_PASS_A = 3'b000,
    ALU_NOT_B  = 3'b001,
    ALU_AND    = 3'b010,
    ALU_ADD    = 3'b011,
    ALU_SHR_B  = 3'b100
  } alu_op_e;

  typedef enum logic [1:0] {
    MEM_NOP = 2'b00,
    MEM_RD  = 2'b01,
    MEM_WR  = 2'b10
  } mem_op_e;

  typedef enum logic [1:0] {
    PC_HOLD  = 2'b00,
    PC_ZERO  = 2'b01,
    PC_INC   = 2'b10,
    PC_X_INC = 2'b11
  } pc_sel_e;

  typedef struct packed {
    alu_op_e alu_op;
    mem_op_e mem_op;
    pc_sel_e pc_sel;
    logic    ac_le;
    logic    di_le;
    logic    ao_le;
    logic    ao_from_x;
    logic    abus_x;
  } ctrl_t;

endpackage

// File: rtl/acc_alu.sv
module acc_alu
  import acc_pkg::*;
#(
  parameter int W = 16
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_PASS_A: y = a;
      ALU_NOT_B:  y = ~b;
      ALU_AND:    y = a & b;
      ALU_ADD:    y = a + b;
      ALU_SHR_B:  y = {1'b0, b[W-1:1]};
      default:    y = a;
    endcase
  end
endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] fetch_opc,
  input  logic [2:0] exec_opc,
  input  logic       acc_neg,
  output ctrl_t      ctrl,
  output logic [3:0] state
);
  state_e state_q, state_d;

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_RESET1;
    else     state_q <= state_d;
  end

  assign state = state_q;

  always_comb begin
    ctrl = '{alu_op: ALU_PASS_A, mem_op: MEM_NOP, pc_sel: PC_HOLD,
             ac_le: 1'b0, di_le: 1'b0, ao_le: 1'b0, ao_from_x: 1'b0,
             abus_x: 1'b0};
    state_d = ST_RESET1;
    unique case (state_q)
      ST_RESET1: begin
        ctrl.pc_sel = PC_ZERO;
        state_d     = ST_RESET2;
      end
      ST_RESET2: begin
        ctrl.ao_le  = 1'b1;
        ctrl.pc_sel = PC_INC;
        state_d     = ST_FETCH;
      end
      ST_FETCH: begin
        ctrl.mem_op = MEM_RD;
        ctrl.di_le  = 1'b1;
        unique case (fetch_opc)
          3'b000, 3'b001: state_d = ST_SOPR;
          3'b010:         state_d = ST_BRN1;
          3'b011:         state_d = ST_JUMP;
          3'b100:         state_d = ST_STORE1;
          3'b101:         state_d = ST_LOAD1;
          default:        state_d = ST_AOPR;
        endcase
      end
      ST_AOPR: begin
        ctrl.alu_op = exec_opc[0] ? ALU_ADD : ALU_AND;
        ctrl.abus_x = 1'b1;
        ctrl.ac_le  = 1'b1;
        ctrl.ao_le  = 1'b1;
        ctrl.pc_sel = PC_INC;
        state_d     = ST_FETCH;
      end
      ST_SOPR: begin
        ctrl.alu_op = exec_opc[0] ? ALU_SHR_B : ALU_NOT_B;
        ctrl.ac_le  = 1'b1;
        ctrl.ao_le  = 1'b1;
        ctrl.pc_sel = PC_INC;
        state_d     = ST_FETCH;
      end
      ST_STORE1, ST_LOAD1: begin
        ctrl.ao_le     = 1'b1;
        ctrl.ao_from_x = 1'b1;
        state_d        = (state_q == ST_LOAD1) ? ST_LOAD2 : ST_STORE2;
      end
      ST_STORE2: begin
        ctrl.mem_op = MEM_WR;
        ctrl.ao_le  = 1'b1;
        ctrl.pc_sel = PC_INC;
        state_d     = ST_FETCH;
      end
      ST_LOAD2: begin
        ctrl.mem_op = MEM_RD;
        ctrl.di_le  = 1'b1;
        state_d     = ST_LOAD3;
      end
      ST_LOAD3: begin
        ctrl.alu_op = ALU_PASS_A;
        ctrl.ac_le  = 1'b1;
        ctrl.ao_le  = 1'b1;
        ctrl.pc_sel = PC_INC;
        state_d     = ST_FETCH;
      end
      ST_BRN1: begin
        ctrl.ao_le  = 1'b1;
        ctrl.pc_sel = PC_INC;
        state_d     = acc_neg ? ST_BRN2 : ST_FETCH;
      end
      ST_BRN2, ST_JUMP: begin
        ctrl.ao_le     = 1'b1;
        ctrl.ao_from_x = 1'b1;
        ctrl.pc_sel    = PC_X_INC;
        state_d        = ST_FETCH;
      end
      default: state_d = ST_RESET1;
    endcase
  end
endmodule

// File: rtl/acc_datapath.sv
module acc_datapath
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] acc,
  output logic [DATA_W-1:0] di,
  output logic [ADDR_W-1:0] pc,
  output logic [ADDR_W-1:0] ao
);
  localparam int PAD_W = DATA_W - ADDR_W;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(2);

  logic [ADDR_W-1:0] x_field;
  logic [DATA_W-1:0] abus, alu_y;

  assign x_field = di[ADDR_W-1:0];
  assign abus    = ctrl.abus_x ? {{PAD_W{1'b0}}, x_field} : di;

  acc_alu #(.W(DATA_W)) u_alu (
    .op (ctrl.alu_op),
    .a  (abus),
    .b  (acc),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      di  <= '0;
      ao  <= '0;
    end else begin
      if (ctrl.ac_le) acc <= alu_y;
      if (ctrl.di_le) di  <= rdata;
      if (ctrl.ao_le) ao  <= ctrl.ao_from_x ? x_field : pc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else begin
      unique case (ctrl.pc_sel)
        PC_ZERO:  pc <= '0;
        PC_INC:   pc <= pc + STEP;
        PC_X_INC: pc <= x_field + STEP;
        default:  pc <= pc;
      endcase
    end
  end
endmodule

// File: rtl/acc_core.sv
module acc_core
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        mem_op,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int OPC_LSB = ADDR_W;

  ctrl_t             ctrl;
  logic [3:0]        state;
  logic [DATA_W-1:0] acc, di;
  logic [ADDR_W-1:0] pc, ao;

  acc_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .fetch_opc (mem_rdata[OPC_LSB+2:OPC_LSB]),
    .exec_opc  (di[OPC_LSB+2:OPC_LSB]),
    .acc_neg   (acc[DATA_W-1]),
    .ctrl      (ctrl),
    .state     (state)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dp (
    .clk   (clk),
    .rst   (rst),
    .ctrl  (ctrl),
    .rdata (mem_rdata),
    .acc   (acc),
    .di    (di),
    .pc    (pc),
    .ao    (ao)
  );

  assign mem_addr  = ao;
  assign mem_op    = ctrl.mem_op;
  assign mem_wdata = acc;
endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk
  import acc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        mem_op,
  input logic [3:0]        state,
  input logic [DATA_W-1:0] acc,
  input logic [DATA_W-1:0] di,
  input logic [ADDR_W-1:0] pc,
  input logic [ADDR_W-1:0] ao
);
  AST_OP_LEGAL: assert property (@(posedge clk) disable iff (rst)
    mem_op != 2'b11); // R11
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> mem_op == 2'b00); // R1
  AST_FETCH_INVARIANT: assert property (@(posedge clk) disable iff (rst)
    state == ST_FETCH |-> pc == ao + ADDR_W'(2)); // R2
  AST_LOAD_RESULT: assert property (@(posedge clk) disable iff (rst)
    state == ST_LOAD3 |=> acc == $past(di)); // R3
  AST_WRITE_SEQ: assert property (@(posedge clk) disable iff (rst)
    mem_op == 2'b10 |-> $past(mem_op) == 2'b00 && $past(mem_op, 2) == 2'b01); // R4
  AST_BRANCH_NEG: assert property (@(posedge clk) disable iff (rst)
    state == ST_BRN2 |-> $past(state) == ST_BRN1 && acc[DATA_W-1]); // R5
  AST_SHR_MSB: assert property (@(posedge clk) disable iff (rst)
    ($past(state) == ST_SOPR && $past(di[ADDR_W+2:ADDR_W]) == 3'b001) |-> !acc[DATA_W-1]); // R7
endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .mem_op (mem_op),
  .state  (state),
  .acc    (acc),
  .di     (di),
  .pc     (pc),
  .ao     (ao)
);

// File: tb/acc_core_test.sv
module acc_core_test;
  localparam int DW = 16;
  localparam int AW = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] mem_addr;
  logic [1:0]    mem_op;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  logic [DW-1:0] mem [0:(1<<(AW-1))-1];

  always #5 clk = ~clk;

  acc_core #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk       (clk),
    .rst       (rst),
    .mem_addr  (mem_addr),
    .mem_op    (mem_op),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata)
  );

  assign mem_rdata = mem[mem_addr[AW-1:1]];

  typedef struct {
    logic [1:0]    op;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    int            gap;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int   total = 0;
  int   bad   = 0;
  int   gapc  = 0;
  bit   done  = 1'b0;

  function automatic logic [DW-1:0] enc(bit ind, logic [4:0] opc, logic [AW-1:0] x);
    return {ind, opc, x};
  endfunction

  task automatic push(logic [1:0] op, logic [AW-1:0] addr, logic [DW-1:0] data,
                      int gap, string tag);
    exp_t e;
    e.op = op; e.addr = addr; e.data = data; e.gap = gap; e.tag = tag;
    exp_q.push_back(e);
  endtask

  task automatic rd(logic [AW-1:0] addr, int gap, string tag);
    push(2'b01, addr, '0, gap, tag);
  endtask

  task automatic wr(logic [AW-1:0] addr, logic [DW-1:0] data, int gap, string tag);
    push(2'b10, addr, data, gap, tag);
  endtask

  // monitor: pops expected accesses and compares op, address, data and spacing
  always @(negedge clk) begin
    if (rst) begin
      gapc = 0;
      total++;
      if (mem_op !== 2'b00) begin
        bad++;
        $display("FAIL R1 op during reset: got %b exp 00", mem_op);
      end
    end else begin
      gapc++;
      if (mem_op !== 2'b00) begin
        if (exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          total++;
          if (mem_op !== e.op || mem_addr !== e.addr || gapc != e.gap ||
              (e.op == 2'b10 && mem_wdata !== e.data)) begin
            bad++;
            $display("FAIL %s: got op=%b addr=%h data=%h gap=%0d exp op=%b addr=%h data=%h gap=%0d",
                     e.tag, mem_op, mem_addr, mem_wdata, gapc, e.op, e.addr, e.data, e.gap);
          end
        end
        gapc = 0;
      end
    end
  end

  initial begin
    for (int i = 0; i < (1 << (AW-1)); i++) mem[i] = '0;
    mem[10'h000 >> 1] = enc(0, 5'b00101, 10'h100); // load
    mem[10'h002 >> 1] = enc(0, 5'b00100, 10'h180); // store
    mem[10'h004 >> 1] = enc(0, 5'b00010, 10'h020); // brn taken
    mem[10'h020 >> 1] = enc(0, 5'b00000, 10'h000); // comp
    mem[10'h022 >> 1] = enc(0, 5'b00010, 10'h040); // brn not taken
    mem[10'h024 >> 1] = enc(0, 5'b00001, 10'h000); // shr
    mem[10'h026 >> 1] = enc(0, 5'b00111, 10'h001); // add
    mem[10'h028 >> 1] = enc(1, 5'b00110, 10'h3FF); // and, flagged
    mem[10'h02A >> 1] = enc(0, 5'b00100, 10'h182); // store
    mem[10'h02C >> 1] = enc(1, 5'b00101, 10'h102); // load, flagged
    mem[10'h02E >> 1] = enc(0, 5'b00111, 10'h001); // add wraps
    mem[10'h030 >> 1] = enc(0, 5'b00100, 10'h184); // store
    mem[10'h032 >> 1] = enc(0, 5'b00000, 10'h000); // comp
    mem[10'h034 >> 1] = enc(0, 5'b00001, 10'h000); // shr
    mem[10'h036 >> 1] = enc(0, 5'b00100, 10'h186); // store
    mem[10'h038 >> 1] = enc(0, 5'b11111, 10'h001); // add, upper bits set
    mem[10'h03A >> 1] = enc(0, 5'b00100, 10'h188); // store
    mem[10'h03C >> 1] = enc(0, 5'b00011, 10'h03C); // jump self
    mem[10'h100 >> 1] = 16'h8001;
    mem[10'h102 >> 1] = 16'hFFFF;
    mem[10'h3FE >> 1] = 16'hFFFF; // would alter results if indirection were honoured

    rd(10'h000, 3, "R1 first fetch");
    rd(10'h100, 2, "R3 load read");
    rd(10'h002, 2, "R3 fetch after load");
    wr(10'h180, 16'h8001, 2, "R4 store loaded value");
    rd(10'h004, 1, "R4 fetch after store");
    rd(10'h020, 3, "R5 branch taken");
    rd(10'h022, 2, "R5 continue at X+2");
    rd(10'h024, 2, "R5 branch not taken");
    rd(10'h026, 2, "R2 sequential fetch");
    rd(10'h028, 2, "R2 sequential fetch");
    rd(10'h02A, 2, "R9 flagged and no extra access");
    wr(10'h182, 16'h0000, 2, "R8 and with immediate");
    rd(10'h02C, 1, "R4 fetch after store");
    rd(10'h102, 2, "R9 flagged load reads X");
    rd(10'h02E, 2, "R9 no second read");
    rd(10'h030, 2, "R8 add");
    wr(10'h184, 16'h0000, 2, "R8 add wraps to zero");
    rd(10'h032, 1, "R2 fetch");
    rd(10'h034, 2, "R7 comp");
    rd(10'h036, 2, "R7 shr");
    wr(10'h186, 16'h7FFF, 2, "R7 comp then logical shr");
    rd(10'h038, 1, "R2 fetch");
    rd(10'h03A, 2, "R10 undecoded bits");
    wr(10'h188, 16'h8000, 2, "R10 upper opcode bits ignored");
    rd(10'h03C, 1, "R6 fetch jump");
    rd(10'h03C, 2, "R6 jump to X");
    rd(10'h03C, 2, "R6 jump repeat");

    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    wait (exp_q.size() == 0);

    // second reset in mid-run restarts from address 0
    rd(10'h000, 3, "R1 restart fetch");
    rd(10'h100, 2, "R1 restart load");
    @(posedge clk);
    #1 rst = 1'b1;
    repeat (2) @(posedge clk);
    #1 rst = 1'b0;
    wait (exp_q.size() == 0);
    repeat (2) @(posedge clk);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: %0d expected accesses pending, exp 0", exp_q.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule